// File: doc/BRIEF.md
# Serial-Loaded Vacuum Fluorescent Display Control Register

This block turns a three-wire serial stream into the parallel on/off levels that drive a multiplexed vacuum fluorescent display: three grid lines and thirty-one anode lines. A host shifts a 34-bit frame in on a slow serial clock. It then raises a load strobe that copies the frame into a holding stage whose bits, after a fixed build-time rearrangement, become the output levels. A grid-enable input can blank the three grid lines at any time and leaves the anodes alone.

The serial clock, serial data and strobe come from outside the block's clock domain. Each passes through a synchronizer, and serial clock edges are detected in the system clock domain, so every stored bit lives in plain synchronous flops. The reset input is active high and asserts at once. Its release is synchronized to the system clock. It clears both the shift stage and the holding stage, so all outputs stay dark until the first load. The rearrangement is a parameter array that gives, for each serial bit position, the output it drives. Elaboration stops if that array is not a true permutation.

Top module: `vfd_serial_driver`

## Requirements
- R1: While reset is asserted, every grid and anode output is 0. After reset, opening the strobe before any serial clock still gives all outputs 0, because the shift stage was cleared.
- R2: With the default mapping, the first of 34 serially sent bits drives grid 1 (grid[0]), the second and third drive grid[1] and grid[2], and the fourth through the 34th drive anode[0] through anode[30].
- R3: Each rising serial clock edge shifts exactly one bit. A 35th bit pushes the first one out, and every earlier bit moves one position toward grid 1.
- R4: While the strobe is high, the outputs follow the shift stage, and they change as further bits are shifted in.
- R5: While the strobe is low, shifting new bits in leaves every output unchanged.
- R6: While grid-enable is 0, all three grid outputs are 0 whatever their stored bits hold, and the anode outputs are unaffected.
- R7: While grid-enable is 1, each grid output equals its stored bit. A stored 1 gives an output of 1 and a stored 0 gives an output of 0.
- R8: The mapping parameter can send serial bit position b to any output. With the mapping b -> 33-b, the first bit sent drives anode[30] and the last drives grid[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, asynchronous assertion |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, sampled on rising serClk |
| strobe | input | 1 | High: holding stage transparent; low: hold |
| gridEn | input | 1 | Grid output enable |
| grid | output | 3 | Grid drive levels, grid[0] is grid 1 |
| anode | output | 31 | Anode drive levels, anode[0] is anode 1 |

## Verification
A corrupted shift stage stays hidden until the next strobe. It then shows up within about three system cycles as a wrong pattern on the anode or grid outputs. A missing or doubled shift shows up as the whole frame displaced by one position. A holding stage that updates while the strobe is low shows up as outputs that change during an idle shift, before any strobe. A broken mapping shows up as the first serial bit landing on the wrong output. Checks made in the strobe-low window therefore separate hold faults from shift faults.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int VFD_BITS   = 34;
  localparam int VFD_GRIDS  = 3;
  localparam int VFD_ANODES = VFD_BITS - VFD_GRIDS;

  // For serial bit position b (0 = first bit sent), the output index it drives.
  // Output indices 0..VFD_GRIDS-1 are grids, the rest are anodes in order.
  typedef int unsigned bitMapT [VFD_BITS];

  typedef struct packed {
    logic shiftEn;    // one-cycle pulse per rising serial clock edge
    logic shiftBit;   // synchronized serial data
    logic latchOpen;  // synchronized strobe level
  } ctrlStrobeT;

  function automatic bitMapT identityMap();
    bitMapT m;
    for (int i = 0; i < VFD_BITS; i++) m[i] = i;
    return m;
  endfunction

  function automatic bit mapIsPerm(bitMapT m);
    logic [VFD_BITS-1:0] seen;
    seen = '0;
    for (int i = 0; i < VFD_BITS; i++) begin
      if (m[i] >= VFD_BITS) return 1'b0;
      if (seen[m[i]]) return 1'b0;
      seen[m[i]] = 1'b1;
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl import vfd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstIn,
  input  logic       serClk,
  input  logic       serData,
  input  logic       strobe,
  output logic       rstInt,
  output ctrlStrobeT strobes
);
  localparam int SYNC_W = 3;

  logic [SYNC_STAGES-1:0] rstPipe;
  logic [SYNC_W-1:0]      syncIn;
  logic [SYNC_W-1:0]      syncOut;
  logic                   clkPrev;

  // Reset: assert immediately, release after SYNC_STAGES clean edges.
  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) rstPipe <= '1;
    else       rstPipe <= {rstPipe[SYNC_STAGES-2:0], 1'b0};
  end
  assign rstInt = rstPipe[SYNC_STAGES-1];

  // Clock, data and strobe share one synchronizer so their latency matches.
  assign syncIn = {serClk, serData, strobe};

  vfd_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rstInt),
    .d   (syncIn),
    .q   (syncOut)
  );

  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) clkPrev <= 1'b0;
    else        clkPrev <= syncOut[2];
  end

  always_comb begin
    strobes.shiftEn   = syncOut[2] & ~clkPrev;
    strobes.shiftBit  = syncOut[1];
    strobes.latchOpen = syncOut[0];
  end
endmodule

// File: rtl/vfd_datapath.sv
module vfd_datapath import vfd_pkg::*; #(
  parameter bitMapT BIT_MAP = identityMap()
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobeT            strobes,
  input  logic                  gridEn,
  output logic [VFD_GRIDS-1:0]  grid,
  output logic [VFD_ANODES-1:0] anode
);
  logic [VFD_BITS-1:0] shiftQ;
  logic [VFD_BITS-1:0] latchQ;
  logic [VFD_BITS-1:0] outVec;

  // New bits enter at the top and walk toward index 0, so the first bit
  // sent sits at index 0 after VFD_BITS shifts.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  shiftQ <= '0;
    else if (strobes.shiftEn) shiftQ <= {strobes.shiftBit, shiftQ[VFD_BITS-1:1]};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    latchQ <= '0;
    else if (strobes.latchOpen) latchQ <= shiftQ;
  end

  always_comb begin
    outVec = '0;
    for (int b = 0; b < VFD_BITS; b++) outVec[BIT_MAP[b]] = latchQ[b];
  end

  assign grid  = outVec[VFD_GRIDS-1:0] & {VFD_GRIDS{gridEn}};
  assign anode = outVec[VFD_BITS-1:VFD_GRIDS];
endmodule

// File: rtl/vfd_serial_driver.sv
module vfd_serial_driver import vfd_pkg::*; #(
  parameter int     SYNC_STAGES = 2,
  parameter bitMapT BIT_MAP     = identityMap()
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  strobe,
  input  logic                  gridEn,
  output logic [VFD_GRIDS-1:0]  grid,
  output logic [VFD_ANODES-1:0] anode
);
  if (!mapIsPerm(BIT_MAP)) begin : g_badMap
    $error("vfd_serial_driver: BIT_MAP is not a permutation of output indices");
  end

  logic       rstInt;
  ctrlStrobeT strobes;

  vfd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstIn   (rst),
    .serClk  (serClk),
    .serData (serData),
    .strobe  (strobe),
    .rstInt  (rstInt),
    .strobes (strobes)
  );

  vfd_datapath #(.BIT_MAP(BIT_MAP)) u_dp (
    .clk     (clk),
    .rst     (rstInt),
    .strobes (strobes),
    .gridEn  (gridEn),
    .grid    (grid),
    .anode   (anode)
  );
endmodule

// File: rtl/vfd_serial_checker.sv
module vfd_serial_checker import vfd_pkg::*; (
  input logic                  clk,
  input logic                  rst,
  input logic                  gridEn,
  input logic [VFD_GRIDS-1:0]  grid,
  input logic [VFD_ANODES-1:0] anode,
  input logic                  shiftEn,
  input logic                  latchOpen
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |-> (grid == '0 && anode == '0));

  // R6
  grid_gate_chk: assert property (@(posedge clk) disable iff (rst) !gridEn |-> grid == '0);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst) !latchOpen |=> $stable(anode));

  // R3
  single_shift_chk: assert property (@(posedge clk) disable iff (rst) shiftEn |=> !shiftEn);
endmodule

bind vfd_serial_driver vfd_serial_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .gridEn    (gridEn),
  .grid      (grid),
  .anode     (anode),
  .shiftEn   (strobes.shiftEn),
  .latchOpen (strobes.latchOpen)
);

// File: tb/sim_vfd_serial_driver.sv
module sim_vfd_serial_driver;
  import vfd_pkg::*;

  function automatic bitMapT revMap();
    bitMapT m;
    for (int i = 0; i < VFD_BITS; i++) m[i] = VFD_BITS - 1 - i;
    return m;
  endfunction
  localparam bitMapT REV_MAP = revMap();

  localparam int NVEC = 6;
  // {gridEn, frame}; frame bit 0 is the first bit sent
  localparam logic [VFD_BITS:0] VEC [NVEC] = '{
    {1'b1, 34'h3_FFFF_FFFF},
    {1'b1, 34'h0_0000_0001},
    {1'b0, 34'h2_AAAA_AAAA},
    {1'b1, 34'h1_5555_5555},
    {1'b1, 34'h2_0000_0008},
    {1'b0, 34'h0_DEAD_BEE5}
  };

  logic clk = 1'b0, rst = 1'b1, serClk = 1'b0, serData = 1'b0, strobe = 1'b0, gridEn = 1'b1;
  logic [VFD_GRIDS-1:0]  grid0, grid1;
  logic [VFD_ANODES-1:0] anode0, anode1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vfd_serial_driver u0 (.clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .strobe(strobe), .gridEn(gridEn), .grid(grid0), .anode(anode0));

  vfd_serial_driver #(.BIT_MAP(REV_MAP)) u1 (.clk(clk), .rst(rst), .serClk(serClk),
    .serData(serData), .strobe(strobe), .gridEn(gridEn), .grid(grid1), .anode(anode1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    serData = b;  waitN(4);
    serClk = 1'b1; waitN(4);
    serClk = 1'b0; waitN(4);
  endtask

  task automatic sendWord(input logic [VFD_BITS-1:0] w);
    for (int i = 0; i < VFD_BITS; i++) sendBit(w[i]);
  endtask

  task automatic pulseStrobe();
    strobe = 1'b1; waitN(6);
    strobe = 1'b0; waitN(4);
  endtask

  function automatic logic [VFD_BITS-1:0] revOut(input logic [VFD_BITS-1:0] w);
    logic [VFD_BITS-1:0] o;
    for (int b = 0; b < VFD_BITS; b++) o[VFD_BITS-1-b] = w[b];
    return o;
  endfunction

  initial begin
    logic [VFD_ANODES-1:0] prevAnode;
    logic [VFD_BITS-1:0]   w, r;
    waitN(5);
    chk("R1 grid in reset", 64'(grid0), 64'(0));
    chk("R1 anode in reset", 64'(anode0), 64'(0));
    rst = 1'b0; waitN(5);
    pulseStrobe();
    chk("R1 grid after first strobe", 64'(grid0), 64'(0));
    chk("R1 anode after first strobe", 64'(anode0), 64'(0));

    prevAnode = '0;
    for (int v = 0; v < NVEC; v++) begin
      gridEn = VEC[v][VFD_BITS];
      w = VEC[v][VFD_BITS-1:0];
      sendWord(w);
      chk("R5 anode held while strobe low", 64'(anode0), 64'(prevAnode));
      pulseStrobe();
      chk(gridEn ? "R2 R7 grid" : "R6 grid gated", 64'(grid0),
          64'(gridEn ? w[VFD_GRIDS-1:0] : 3'b000));
      chk("R2 anode", 64'(anode0), 64'(w[VFD_BITS-1:VFD_GRIDS]));
      r = revOut(w);
      chk("R8 remapped grid", 64'(grid1), 64'(gridEn ? r[VFD_GRIDS-1:0] : 3'b000));
      chk("R8 remapped anode", 64'(anode1), 64'(r[VFD_BITS-1:VFD_GRIDS]));
      prevAnode = w[VFD_BITS-1:VFD_GRIDS];
    end

    // R3: a 35th bit pushes the first one out
    gridEn = 1'b1;
    sendWord(34'h0_0000_0005);
    sendBit(1'b1);
    pulseStrobe();
    chk("R3 grid after 35 bits", 64'(grid0), 64'(3'b010));
    chk("R3 anode after 35 bits", 64'(anode0), 64'(31'h4000_0000));

    // R4: transparent while strobe high
    sendWord('0);
    pulseStrobe();
    strobe = 1'b1; waitN(6);
    sendBit(1'b1);
    chk("R4 anode follows shift", 64'(anode0), 64'(31'h4000_0000));
    sendBit(1'b0);
    chk("R4 anode follows next shift", 64'(anode0), 64'(31'h2000_0000));
    strobe = 1'b0; waitN(4);

    // R6 / R7: grid enable toggling on a fixed frame
    sendWord(34'h3_FFFF_FFFF);
    pulseStrobe();
    gridEn = 1'b0; waitN(2);
    chk("R6 grid forced low", 64'(grid0), 64'(0));
    chk("R6 anode unaffected", 64'(anode0), 64'(31'h7FFF_FFFF));
    gridEn = 1'b1; waitN(2);
    chk("R7 grid follows latch", 64'(grid0), 64'(3'b111));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule